// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers eleven peripheral request lines into a single interrupt request for the processor. Each source owns a latched status bit and an enable mask bit. A status bit is set when its request line goes from low to high. It stays set until software acknowledges it by writing a zero into that bit position. The processor request is the OR over all sources of status AND mask.

Software reaches the two registers over a small register bus. The bus carries a select, a write strobe, an access size (byte, half-word or word) and an offset inside the controller's 16-byte window. Reads are combinational and return data in the same cycle as the request. Writes take effect at the next rising clock edge.

Top module: `irq_gather_ctrl`

## Requirements
- R1: The sources have fixed bit positions: 0 vertical blank, 1 graphics, 2 optical drive, 3 DMA, 4 timer 0, 5 timer 1, 6 timer 2, 7 peripheral port, 8 serial port, 9 sound, 10 parallel port. Request bit k sets status bit k and no other bit.
- R2: A request line that is high at a clock edge, after being low at the edge before, sets its status bit at that edge. A high level lasting a single cycle is enough. The new status can be read from the following cycle.
- R3: A request line held high sets its status bit only once. After software clears the bit, it stays clear until the line has gone low and risen again.
- R4: A write to the status register (half-word offset 0x0) clears each status bit whose write-data bit is 0. Each status bit whose write-data bit is 1 keeps its value.
- R5: A write to the mask register (half-word offset 0x4) loads mask bits 10..0 from write-data bits 10..0.
- R6: `irq_o` equals the OR over all sources of status AND mask. It follows the register state, so it changes in the cycle after the edge or write that changed that state.
- R7: A word access is split into two half-words. Bus bits 15..0 go to the half-word at the offset with bits 1..0 cleared, and bus bits 31..16 go to that offset plus 2. A half-word access uses bus bits 15..0 and ignores offset bit 0. Offsets other than 0x0 and 0x4 read as zero, and writes to them have no effect.
- R8: Status bits 15..11 and mask bits 15..11 always read as zero.
- R9: Byte accesses (`bus_size` 0) and the reserved size code 3 return zero on a read and change no state on a write.
- R10: A synchronous active-high `rst` clears status, mask, the stored previous request levels and `irq_o`.
- R11: If a rising edge and a status write that clears the same bit arrive in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 11 | Peripheral request lines, bit positions as in R1 |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| bus_addr | input | 4 | Byte offset inside the controller window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read is in progress |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
Each source is pulsed alone for one cycle, which shows that a single-cycle pulse latches and confirms the bit position of every source. All sources are then pulsed together to expose the always-zero upper status bits. A request held high across an acknowledge tells edge capture apart from level capture. A rising edge placed in the same cycle as a clearing write shows which of the two wins. Word, half-word and byte accesses at implemented and unimplemented offsets separate the half-word split from stray decodes, while masked and unmasked pending sources, checked against the model every cycle, separate the AND-OR combine from a plain OR of status.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int NUM_SOURCES = 11;

   localparam int SRC_VBLANK   = 0;
   localparam int SRC_GRAPHICS = 1;
   localparam int SRC_OPTICAL  = 2;
   localparam int SRC_DMA      = 3;
   localparam int SRC_TIMER0   = 4;
   localparam int SRC_TIMER1   = 5;
   localparam int SRC_TIMER2   = 6;
   localparam int SRC_PERIPH   = 7;
   localparam int SRC_SERIAL   = 8;
   localparam int SRC_SOUND    = 9;
   localparam int SRC_PARALLEL = 10;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
   parameter int SRC_W = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SRC_W-1:0] req,
   output logic [SRC_W-1:0] rise
);
   for (genvar k = 0; k < SRC_W; k++) begin : g_src
      logic prev_q;
      always_ff @(posedge clk) begin
         if (rst) prev_q <= 1'b0;
         else     prev_q <= req[k];
      end
      assign rise[k] = req[k] & ~prev_q;
   end
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int HALF_W   = 16,
   parameter int SRC_W    = 11,
   parameter int STAT_OFS = 0,
   parameter int MASK_OFS = 4
) (
   input  logic                sel,
   input  logic                we,
   input  logic [1:0]          size,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [2*HALF_W-1:0] wdata,
   input  logic [SRC_W-1:0]    stat_rd,
   input  logic [SRC_W-1:0]    mask_rd,
   output logic                stat_we,
   output logic [SRC_W-1:0]    stat_wd,
   output logic                mask_we,
   output logic [SRC_W-1:0]    mask_wd,
   output logic [2*HALF_W-1:0] rdata
);
   localparam int IDX_W = ADDR_W - 1;
   localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(STAT_OFS / 2);
   localparam logic [IDX_W-1:0] MASK_IDX = IDX_W'(MASK_OFS / 2);

   acc_size_e sz;
   logic      is_word;
   logic      half_ok;
   logic [1:0] st_hit;
   logic [1:0] mk_hit;
   logic [SRC_W-1:0] lane_src [2];

   logic unused_addr_lsb;
   logic unused_wdata;
   assign unused_addr_lsb = addr[0];
   assign unused_wdata    = ^wdata;

   assign sz      = acc_size_e'(size);
   assign is_word = (sz == SZ_WORD);
   assign half_ok = sel && ((sz == SZ_HALF) || is_word);

   for (genvar l = 0; l < 2; l++) begin : g_lane
      logic             on;
      logic [IDX_W-1:0] idx;
      logic [HALF_W-1:0] rd;
      assign on  = half_ok && ((l == 0) || is_word);
      assign idx = (is_word || (l == 1)) ? {addr[ADDR_W-1:2], 1'(l)} : addr[ADDR_W-1:1];
      assign st_hit[l]   = on && (idx == STAT_IDX);
      assign mk_hit[l]   = on && (idx == MASK_IDX);
      assign lane_src[l] = wdata[l*HALF_W +: SRC_W];
      always_comb begin
         rd = '0;
         if (!we && st_hit[l])      rd = HALF_W'(stat_rd);
         else if (!we && mk_hit[l]) rd = HALF_W'(mask_rd);
      end
      assign rdata[l*HALF_W +: HALF_W] = rd;
   end

   always_comb begin
      stat_wd = '0;
      mask_wd = '0;
      for (int l = 0; l < 2; l++) begin
         if (st_hit[l]) stat_wd = stat_wd | lane_src[l];
         if (mk_hit[l]) mask_wd = mask_wd | lane_src[l];
      end
   end

   assign stat_we = we && (|st_hit);
   assign mask_we = we && (|mk_hit);
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
   parameter int SRC_W   = 11,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SRC_W-1:0] stat,
   input  logic [SRC_W-1:0] mask,
   output logic             irq
);
   logic any_live;
   assign any_live = |(stat & mask);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (rst) irq_q <= 1'b0;
         else     irq_q <= any_live;
      end
      assign irq = irq_q;
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign irq = any_live;
   end
endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
   import irq_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int HALF_W   = 16,
   parameter int SRC_W    = NUM_SOURCES,
   parameter int STAT_OFS = 0,
   parameter int MASK_OFS = 4,
   parameter bit REG_OUT  = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SRC_W-1:0]    req_i,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [1:0]          bus_size,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [2*HALF_W-1:0] bus_wdata,
   output logic [2*HALF_W-1:0] bus_rdata,
   output logic                irq_o
);
   if (SRC_W > HALF_W) begin : g_chk_width
      $error("irq_gather_ctrl: SRC_W must fit in one half-word");
   end
   if (ADDR_W < 3) begin : g_chk_addr
      $error("irq_gather_ctrl: ADDR_W must be at least 3");
   end
   if ((STAT_OFS % 4) != 0 || (MASK_OFS % 4) != 0 || STAT_OFS == MASK_OFS) begin : g_chk_ofs
      $error("irq_gather_ctrl: register offsets must be distinct and word aligned");
   end

   logic [SRC_W-1:0] rise_w;
   logic [SRC_W-1:0] stat_q;
   logic [SRC_W-1:0] mask_q;
   logic             stat_we;
   logic [SRC_W-1:0] stat_wd;
   logic             mask_we;
   logic [SRC_W-1:0] mask_wd;
   logic [SRC_W-1:0] keep;

   irq_edge_capture #(.SRC_W(SRC_W)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .req  (req_i),
      .rise (rise_w)
   );

   irq_reg_decode #(
      .ADDR_W   (ADDR_W),
      .HALF_W   (HALF_W),
      .SRC_W    (SRC_W),
      .STAT_OFS (STAT_OFS),
      .MASK_OFS (MASK_OFS)
   ) u_dec (
      .sel     (bus_sel),
      .we      (bus_we),
      .size    (bus_size),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .stat_rd (stat_q),
      .mask_rd (mask_q),
      .stat_we (stat_we),
      .stat_wd (stat_wd),
      .mask_we (mask_we),
      .mask_wd (mask_wd),
      .rdata   (bus_rdata)
   );

   assign keep = stat_we ? stat_wd : '1;

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q <= '0;
         mask_q <= '0;
      end else begin
         stat_q <= (stat_q & keep) | rise_w;
         if (mask_we) mask_q <= mask_wd;
      end
   end

   irq_combine #(.SRC_W(SRC_W), .REG_OUT(REG_OUT)) u_comb (
      .clk  (clk),
      .rst  (rst),
      .stat (stat_q),
      .mask (mask_q),
      .irq  (irq_o)
   );
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
   parameter int SRC_W   = 11,
   parameter bit REG_OUT = 1'b0
) (
   input logic             clk,
   input logic             rst,
   input logic [SRC_W-1:0] rise,
   input logic [SRC_W-1:0] stat,
   input logic [SRC_W-1:0] mask,
   input logic             stat_we,
   input logic [SRC_W-1:0] stat_wd,
   input logic             mask_we,
   input logic [SRC_W-1:0] mask_wd,
   input logic             bus_sel,
   input logic             bus_we,
   input logic [1:0]       bus_size,
   input logic             irq
);
   p_edge_sets_r2: assert property (@(posedge clk) disable iff (rst)
      (rise != '0) |=> ((stat & $past(rise)) == $past(rise)));

   p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((stat & ~$past(stat) & ~$past(rise)) == '0));

   p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
      stat_we |=> ((stat & ~$past(stat_wd) & ~$past(rise)) == '0));

   p_ack_keeps_r4: assert property (@(posedge clk) disable iff (rst)
      stat_we |=> (($past(stat) & $past(stat_wd) & ~stat) == '0));

   p_mask_load_r5: assert property (@(posedge clk) disable iff (rst)
      mask_we |=> (mask == $past(mask_wd)));

   p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !mask_we |=> (mask == $past(mask)));

   if (REG_OUT) begin : g_irq_reg
      p_irq_combine_r6: assert property (@(posedge clk) disable iff (rst)
         1'b1 |=> (irq == $past(|(stat & mask))));
   end else begin : g_irq_comb
      p_irq_combine_r6: assert property (@(posedge clk) disable iff (rst)
         irq == (|(stat & mask)));
   end

   p_byte_ignored_r9: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && bus_we && (bus_size == 2'd0) && (rise == '0))
      |=> ((mask == $past(mask)) && (stat == $past(stat))));

   p_reset_clear_r10: assert property (@(posedge clk)
      rst |=> ((stat == '0) && (mask == '0)));

   p_edge_wins_r11: assert property (@(posedge clk) disable iff (rst)
      (stat_we && (rise != '0)) |=> ((stat & $past(rise)) == $past(rise)));
endmodule

bind irq_gather_ctrl irq_gather_chk #(.SRC_W(SRC_W), .REG_OUT(REG_OUT)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .rise     (rise_w),
   .stat     (stat_q),
   .mask     (mask_q),
   .stat_we  (stat_we),
   .stat_wd  (stat_wd),
   .mask_we  (mask_we),
   .mask_wd  (mask_wd),
   .bus_sel  (bus_sel),
   .bus_we   (bus_we),
   .bus_size (bus_size),
   .irq      (irq_o)
);

// File: tb/irq_gather_ctrl_tb.sv
module irq_gather_ctrl_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [10:0] req = '0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_size = 2'd1;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_P/2) clk = ~clk;

   irq_gather_ctrl dut_i (
      .clk       (clk),
      .rst       (rst),
      .req_i     (req),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_size  (bus_size),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   // behavioural reference model
   bit [10:0] m_stat = '0;
   bit [10:0] m_mask = '0;
   bit [10:0] m_prev = '0;
   bit [10:0] m_keep;
   bit [10:0] m_nmask;

   task automatic model_half(input int a, input bit [15:0] d);
      if (a == 0) m_keep = d[10:0];
      else if (a == 4) m_nmask = d[10:0];
   endtask

   always @(posedge clk) begin
      if (rst) begin
         m_stat = '0; m_mask = '0; m_prev = '0;
      end else begin
         m_keep  = '1;
         m_nmask = m_mask;
         if (bus_sel && bus_we) begin
            if (bus_size == 2'd1) model_half(int'(bus_addr) & 14, bus_wdata[15:0]);
            else if (bus_size == 2'd2) begin
               model_half(int'(bus_addr) & 12, bus_wdata[15:0]);
               model_half((int'(bus_addr) & 12) + 2, bus_wdata[31:16]);
            end
         end
         for (int i = 0; i < 11; i++) begin
            if (!m_keep[i]) m_stat[i] = 1'b0;
            if (req[i] && !m_prev[i]) m_stat[i] = 1'b1;
         end
         m_mask = m_nmask;
         m_prev = req;
      end
   end

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // per-cycle comparison of the combined output against the model
   always begin
      @(posedge clk);
      #1;
      check("R6 per-cycle irq", {31'b0, irq_o}, {31'b0, |(m_stat & m_mask)});
   end

   task automatic bus_wr(input logic [1:0] sz, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] sz, input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_size = sz; bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
      bus_sel = 1'b0;
   endtask

   task automatic pulse(input logic [10:0] v);
      @(negedge clk);
      req = v;
      @(negedge clk);
      req = '0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R10 reset state
      bus_rd(2'd1, 4'h0, 32'h0, "R10 status after reset");
      bus_rd(2'd1, 4'h4, 32'h0, "R10 mask after reset");
      check("R10 irq after reset", {31'b0, irq_o}, 32'h0);

      // R5 / R8 mask load and upper bits
      bus_wr(2'd1, 4'h4, 32'h0000_FFFF);
      bus_rd(2'd1, 4'h4, 32'h0000_07FF, "R5 R8 mask load all ones");
      bus_wr(2'd1, 4'h4, 32'h0000_0000);
      bus_rd(2'd1, 4'h4, 32'h0, "R5 mask load zero");

      // R1 / R2 / R4 per-source single-cycle pulse then acknowledge
      for (int i = 0; i < 11; i++) begin
         pulse(11'(1 << i));
         bus_rd(2'd1, 4'h0, 32'(1 << i), $sformatf("R1 R2 source %0d position", i));
         bus_wr(2'd1, 4'h0, 32'h0000_FFFF ^ 32'(1 << i));
         bus_rd(2'd1, 4'h0, 32'h0, $sformatf("R4 ack source %0d", i));
      end

      // R4 ones keep, zeros clear
      pulse(11'h0C3);
      bus_wr(2'd1, 4'h0, 32'h0000_FF7E);
      bus_rd(2'd1, 4'h0, 32'h0000_0042, "R4 partial acknowledge");

      // R8 all sources together, upper status bits zero
      pulse(11'h7FF);
      bus_rd(2'd1, 4'h0, 32'h0000_07FF, "R8 status upper bits zero");
      bus_wr(2'd1, 4'h0, 32'h0);

      // R3 held level sets once
      @(negedge clk); req[3] = 1'b1;
      repeat (2) @(negedge clk);
      bus_rd(2'd1, 4'h0, 32'h0000_0008, "R3 held level sets");
      bus_wr(2'd1, 4'h0, 32'h0000_FFF7);
      repeat (3) @(negedge clk);
      bus_rd(2'd1, 4'h0, 32'h0, "R3 held level stays cleared");
      @(negedge clk); req[3] = 1'b0;
      pulse(11'h008);
      bus_rd(2'd1, 4'h0, 32'h0000_0008, "R3 new edge after release");
      bus_wr(2'd1, 4'h0, 32'h0);

      // R6 masked combine
      bus_wr(2'd1, 4'h4, 32'h0000_0020);
      pulse(11'h010);
      bus_rd(2'd1, 4'h0, 32'h0000_0010, "R6 masked source latched");
      check("R6 masked source gives no irq", {31'b0, irq_o}, 32'h0);
      pulse(11'h020);
      check("R6 unmasked source raises irq", {31'b0, irq_o}, 32'h1);
      bus_wr(2'd1, 4'h0, 32'h0000_FFDF);
      check("R6 irq drops on ack", {31'b0, irq_o}, 32'h0);
      bus_wr(2'd1, 4'h4, 32'h0000_0010);
      check("R6 irq on mask enable of pending", {31'b0, irq_o}, 32'h1);
      bus_wr(2'd1, 4'h0, 32'h0);

      // R7 word split and unimplemented offsets
      bus_wr(2'd2, 4'h4, 32'hFFFF_0155);
      bus_rd(2'd2, 4'h4, 32'h0000_0155, "R7 word mask access");
      pulse(11'h280);
      bus_wr(2'd1, 4'h2, 32'h0000_0000);
      bus_rd(2'd1, 4'h0, 32'h0000_0280, "R7 write at offset 2 ignored");
      bus_rd(2'd2, 4'h0, 32'h0000_0280, "R7 word status read");
      bus_wr(2'd2, 4'h0, 32'h0000_FF7F);
      bus_rd(2'd1, 4'h0, 32'h0000_0200, "R7 word status acknowledge");
      bus_rd(2'd1, 4'h6, 32'h0, "R7 offset 6 reads zero");
      bus_rd(2'd1, 4'h8, 32'h0, "R7 offset 8 reads zero");
      bus_rd(2'd1, 4'h5, 32'h0000_0155, "R7 half offset bit0 ignored");
      bus_wr(2'd2, 4'h6, 32'h0000_0003);
      bus_rd(2'd1, 4'h4, 32'h0000_0003, "R7 word address low bits cleared");
      bus_wr(2'd1, 4'h4, 32'h0000_0155);

      // R9 byte and reserved size ignored
      bus_wr(2'd0, 4'h4, 32'h0);
      bus_wr(2'd0, 4'h0, 32'h0);
      bus_wr(2'd3, 4'h4, 32'h0);
      bus_rd(2'd1, 4'h4, 32'h0000_0155, "R9 byte write leaves mask");
      bus_rd(2'd1, 4'h0, 32'h0000_0200, "R9 byte write leaves status");
      bus_rd(2'd0, 4'h4, 32'h0, "R9 byte read zero");
      bus_rd(2'd3, 4'h0, 32'h0, "R9 reserved size read zero");

      // R11 edge versus clearing write in the same cycle
      bus_wr(2'd1, 4'h0, 32'h0);
      @(negedge clk);
      req[2] = 1'b1;
      bus_sel = 1'b1; bus_we = 1'b1; bus_size = 2'd1; bus_addr = 4'h0; bus_wdata = 32'h0;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; req[2] = 1'b0;
      bus_rd(2'd1, 4'h0, 32'h0000_0004, "R11 edge wins over clear");

      // R10 reset mid-run
      bus_wr(2'd1, 4'h4, 32'h0000_0004);
      check("R10 irq before reset", {31'b0, irq_o}, 32'h1);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      bus_rd(2'd1, 4'h0, 32'h0, "R10 status cleared by reset");
      bus_rd(2'd1, 4'h4, 32'h0, "R10 mask cleared by reset");
      check("R10 irq cleared by reset", {31'b0, irq_o}, 32'h0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule